// File: doc/BRIEF.md
# Synchronous Byte-to-Serial Configuration Port

This block is the front end of a configuration load. A host puts bytes on a parallel bus, and the block samples them on a free-running configuration clock. It then re-emits each byte as a serial bit stream. That stream goes to an internal configuration chain as a bit with a valid strobe. The same stream also goes to an output pin that feeds the data input of the next device in a daisy chain.

A load starts when the handshake input is seen high. The first byte is taken on the second rising edge that sees the handshake high. After that, a byte is taken on every eighth rising edge until the programmed number of bytes has been loaded. Bits leave most-significant first, one per clock. The pin copy changes on the falling edge, half a period after the internal bit. The host must keep the clock running after the last byte so that its bits can drain. A done flag rises only when the last bit has left the shifter. Dropping the handshake at any time aborts the load.

Top module: `cfg_byte_serializer`

## Requirements
- R1: While `rst_n` is low, `ser_pin_o`, `ser_bit_o`, `ser_vld_o`, `byte_req_o` and `done_o` are all 0, and after reset the block waits for the handshake.
- R2: If the first rising edge that sees `start_i` high is edge 1, the first byte on `data_i` is captured on edge 2.
- R3: Each later byte is captured exactly 8 rising edges after the previous capture, until `byte_total_i` bytes have been captured. A byte presented on any other edge is never used.
- R4: Starting at a capture edge, `ser_bit_o` shows bit 7 of the captured byte, then bits 6 down to 0 after each of the following 7 rising edges. `ser_vld_o` is 1 exactly while a captured bit is shown, so the stream has no gaps between bytes.
- R5: On each falling edge, `ser_pin_o` takes the value of `ser_bit_o` when `ser_vld_o` is 1, and 0 otherwise.
- R6: `byte_req_o` is 1 exactly during the one clock period that ends with each capture edge, and 0 in all other periods.
- R7: `done_o` becomes 1 on the eighth rising edge after the last capture, with `ser_vld_o` 0 at that point. It stays 1 while `start_i` stays high.
- R8: If `start_i` is low at a rising edge during a load, the block returns to idle on that edge: `ser_vld_o`, `done_o` and `byte_req_o` are 0 and no further byte is captured.
- R9: With `byte_total_i` equal to 0, no byte is captured, `byte_req_o` stays 0 and `done_o` becomes 1 on edge 2.
- R10: `start_i` low at a rising edge clears `done_o`, and a later high level starts a fresh load that follows R2 to R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration clock; capture on rising edge, pin update on falling edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Handshake; high runs a load, low aborts or finishes it |
| byte_total_i | input | CW | Number of bytes in the image, held stable during a load |
| data_i | input | DW | Parallel byte from the host |
| ser_pin_o | output | 1 | Serial output for downstream devices, falling-edge timed |
| ser_bit_o | output | 1 | Internal serial bit, rising-edge timed |
| ser_vld_o | output | 1 | Qualifies `ser_bit_o` |
| byte_req_o | output | 1 | High in the period before each capture edge |
| done_o | output | 1 | Last bit has left the shifter |

## Verification
The bench builds the block with an 8-bit byte and a 3-bit byte count. This lets it sweep every image length from 0 to 7 bytes, so the zero-length case and the longest image are both reached. For each length it checks every cycle of the stream, both the rising-edge bit and the falling-edge pin. It also drops the handshake at the edges around a capture and in the middle of a byte, and applies reset during a load. The byte offered on every edge that is not a capture edge is the complement of the expected byte, so a capture one edge early or late shows up as wrong bits.

// File: rtl/cfg_byte_serializer_pkg.sv
package cfg_byte_serializer_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARM   = 2'd1,
        ST_SHIFT = 2'd2,
        ST_DONE  = 2'd3
    } ser_state_e;

endpackage

// File: rtl/cfg_byte_serializer_ctrl.sv
module cfg_byte_serializer_ctrl
    import cfg_byte_serializer_pkg::*;
#(
    parameter int DW = 8,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic [CW-1:0] total_i,
    output logic          load_o,
    output logic          shift_o,
    output logic          clear_o,
    output logic          vld_o,
    output logic          done_o,
    output logic          req_o
);
    localparam int BW = (DW > 1) ? $clog2(DW) : 1;
    localparam logic [BW-1:0] LAST_BIT = BW'(DW - 1);

    typedef struct packed {
        ser_state_e    st;
        logic [BW-1:0] bitcnt;
        logic [CW-1:0] bytecnt;
        logic          vld;
        logic          done;
    } ctrl_s;

    ctrl_s r_d, r_q;
    logic  more_bytes;
    logic  byte_edge;

    assign more_bytes = (r_q.bytecnt != total_i);
    assign byte_edge  = (r_q.st == ST_ARM && total_i != '0) ||
                        (r_q.st == ST_SHIFT && r_q.bitcnt == LAST_BIT && more_bytes);

    always_comb begin
        r_d     = r_q;
        load_o  = 1'b0;
        shift_o = 1'b0;
        clear_o = !start_i;
        if (!start_i) begin
            r_d.st      = ST_IDLE;
            r_d.bitcnt  = '0;
            r_d.bytecnt = '0;
            r_d.vld     = 1'b0;
            r_d.done    = 1'b0;
        end else begin
            unique case (r_q.st)
                ST_IDLE: begin
                    r_d.st      = ST_ARM;
                    r_d.bytecnt = '0;
                end
                ST_ARM: begin
                    if (total_i == '0) begin
                        r_d.st   = ST_DONE;
                        r_d.done = 1'b1;
                    end else begin
                        load_o      = 1'b1;
                        r_d.st      = ST_SHIFT;
                        r_d.bitcnt  = '0;
                        r_d.bytecnt = r_q.bytecnt + 1'b1;
                        r_d.vld     = 1'b1;
                    end
                end
                ST_SHIFT: begin
                    if (r_q.bitcnt != LAST_BIT) begin
                        shift_o    = 1'b1;
                        r_d.bitcnt = r_q.bitcnt + 1'b1;
                    end else if (more_bytes) begin
                        load_o      = 1'b1;
                        r_d.bitcnt  = '0;
                        r_d.bytecnt = r_q.bytecnt + 1'b1;
                    end else begin
                        shift_o  = 1'b1;
                        r_d.st   = ST_DONE;
                        r_d.vld  = 1'b0;
                        r_d.done = 1'b1;
                    end
                end
                default: r_d.st = ST_DONE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, bitcnt: '0, bytecnt: '0, vld: 1'b0, done: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign vld_o  = r_q.vld;
    assign done_o = r_q.done;
    assign req_o  = byte_edge;

    // R7: done and a valid bit never coexist
    a_r7_done_not_valid: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !vld_o);

    // R6: a request answered with the handshake high yields a valid byte
    a_r6_req_then_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (req_o && start_i) |=> (vld_o && r_q.bitcnt == '0));

    // R8: handshake low leaves nothing active on the next edge
    a_r8_abort_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !start_i |=> (!vld_o && !done_o && !req_o));

    // R7, R9: done rises only after the last bit or for an empty image
    a_r7_done_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> ($past(r_q.bitcnt) == LAST_BIT || $past(total_i) == '0));

endmodule

// File: rtl/cfg_byte_serializer_shift.sv
module cfg_byte_serializer_shift #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic          shift_i,
    input  logic          clear_i,
    input  logic [DW-1:0] data_i,
    output logic          bit_o
);
    logic [DW-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = sh_q;
        if (clear_i) begin
            sh_d = '0;
        end else if (load_i) begin
            sh_d = data_i;
        end else if (shift_i) begin
            sh_d = {sh_q[DW-2:0], 1'b0};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q <= '0;
        end else begin
            sh_q <= sh_d;
        end
    end

    assign bit_o = sh_q[DW-1];

    // R4: bits leave most-significant first, one per edge
    a_r4_msb_first: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_i && !load_i && !clear_i) |=> (sh_q[DW-1] == $past(sh_q[DW-2])));

    // R3: a capture puts the bus byte into the shifter
    a_r3_load_byte: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && !clear_i) |=> (sh_q == $past(data_i)));

endmodule

// File: rtl/cfg_byte_serializer_pin.sv
module cfg_byte_serializer_pin (
    input  logic clk,
    input  logic rst_n,
    input  logic vld_i,
    input  logic bit_i,
    output logic pin_o
);
    logic pin_d, pin_q;

    always_comb begin
        pin_d = vld_i ? bit_i : 1'b0;
    end

    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pin_q <= 1'b0;
        end else begin
            pin_q <= pin_d;
        end
    end

    assign pin_o = pin_q;

endmodule

// File: rtl/cfg_byte_serializer.sv
module cfg_byte_serializer #(
    parameter int DW = 8,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic [CW-1:0] byte_total_i,
    input  logic [DW-1:0] data_i,
    output logic          ser_pin_o,
    output logic          ser_bit_o,
    output logic          ser_vld_o,
    output logic          byte_req_o,
    output logic          done_o
);
    logic load, shift, clear, vld, sbit;

    cfg_byte_serializer_ctrl #(.DW(DW), .CW(CW)) i_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_i),
        .total_i (byte_total_i),
        .load_o  (load),
        .shift_o (shift),
        .clear_o (clear),
        .vld_o   (vld),
        .done_o  (done_o),
        .req_o   (byte_req_o)
    );

    cfg_byte_serializer_shift #(.DW(DW)) i_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (load),
        .shift_i (shift),
        .clear_i (clear),
        .data_i  (data_i),
        .bit_o   (sbit)
    );

    cfg_byte_serializer_pin i_pin (
        .clk   (clk),
        .rst_n (rst_n),
        .vld_i (vld),
        .bit_i (sbit),
        .pin_o (ser_pin_o)
    );

    assign ser_bit_o = sbit;
    assign ser_vld_o = vld;

    // R5: outside a valid bit the internal line is quiet
    a_r5_quiet_when_invalid: assert property (@(posedge clk) disable iff (!rst_n)
        !ser_vld_o |-> !ser_bit_o);

endmodule

// File: tb/test_cfg_byte_serializer.sv
module test_cfg_byte_serializer;
    localparam int DW = 8;
    localparam int CW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic [CW-1:0] byte_total_i = '0;
    logic [DW-1:0] data_i = '0;
    logic          ser_pin_o, ser_bit_o, ser_vld_o, byte_req_o, done_o;

    int n_tests = 0;
    int n_fail  = 0;

    cfg_byte_serializer #(.DW(DW), .CW(CW)) i_cfg_byte_serializer (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .byte_total_i (byte_total_i),
        .data_i       (data_i),
        .ser_pin_o    (ser_pin_o),
        .ser_bit_o    (ser_bit_o),
        .ser_vld_o    (ser_vld_o),
        .byte_req_o   (byte_req_o),
        .done_o       (done_o)
    );

    always #5 clk = ~clk;

    function automatic logic [7:0] img(input int run, input int k);
        return 8'((run * 53 + k * 29 + 7) & 255);
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s act=%0d exp=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic check_idle(input string req);
        check(req, ser_vld_o, 0);
        check(req, done_o, 0);
        check(req, byte_req_o, 0);
        check(req, ser_bit_o, 0);
    endtask

    // one load of n bytes; abort_at / rst_at = cycle index at which to act, 0 = never
    task automatic run_load(input int run, input int n, input int abort_at, input int rst_at);
        int  t_end;
        bit  vld_e, bit_e;
        t_end = 8 * n + 4;
        byte_total_i = CW'(n);
        data_i = ~img(run, 0);
        start_i = 1'b1;
        for (int t = 1; t <= t_end; t++) begin
            int rel;
            @(posedge clk); #1;
            rel   = t - 2;
            vld_e = (t >= 2) && (rel < 8 * n);
            bit_e = vld_e ? img(run, rel / 8)[7 - (rel % 8)] : 1'b0;
            check("R4 valid", ser_vld_o, int'(vld_e));
            if (vld_e) check("R2/R3/R4 serial bit", ser_bit_o, int'(bit_e));
            check("R7/R9 done", done_o, int'(t >= 2 + 8 * n));
            check("R6 byte request", byte_req_o,
                  int'(n > 0 && (t - 1) % 8 == 0 && (t - 1) / 8 < n));
            @(negedge clk); #1;
            check("R5 pin", ser_pin_o, int'(vld_e && bit_e));
            if (rst_at == t) begin
                rst_n = 1'b0;
                start_i = 1'b0;
                #1;
                check("R1 reset pin", ser_pin_o, 0);
                check_idle("R1 reset");
                @(negedge clk); #1;
                rst_n = 1'b1;
                return;
            end
            if (abort_at == t) begin
                start_i = 1'b0;
                @(posedge clk); #1;
                check_idle("R8 abort");
                @(negedge clk); #1;
                check("R8 abort pin", ser_pin_o, 0);
                return;
            end
            if (t + 1 >= 2 && (t - 1) % 8 == 0 && (t - 1) / 8 < n)
                data_i = img(run, (t - 1) / 8);
            else
                data_i = ~img(run, t / 8);
        end
        check("R7 done held", done_o, 1);
        start_i = 1'b0;
        @(posedge clk); #1;
        check_idle("R10 done cleared");
        @(negedge clk); #1;
    endtask

    initial begin
        #2;
        check("R1 reset pin", ser_pin_o, 0);
        check_idle("R1 reset");
        @(negedge clk); #1;
        rst_n = 1'b1;
        @(negedge clk); #1;
        check_idle("R1 idle after reset");
        for (int n = 0; n < (1 << CW); n++) run_load(n, n, 0, 0);
        run_load(20, 5, 1, 0);
        run_load(21, 5, 9, 0);
        run_load(22, 5, 14, 0);
        run_load(23, 5, 21, 0);
        run_load(24, 7, 0, 0);
        run_load(25, 3, 0, 12);
        run_load(26, 3, 0, 0);
        run_load(27, 1, 0, 0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #1_000_000;
        n_fail++;
        n_tests++;
        $display("FAIL watchdog R10 act=running exp=finished");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule